// File: doc/BRIEF.md
# Dual-Select Static RAM with Split Data Buses

This block is a clocked, synthesizable model of a word-organised static RAM. It has one input data bus and one output data bus. Two active-low select inputs must both be low before the array responds. An active-low write strobe picks between reading and writing. An active-low output gate controls whether the output bus is driven. The output drive is represented by an enable signal that travels with the data. While the enable is low, the data bus reads zero, which stands in for a floated bus. A power-down flag rises whenever the part is not selected.

All control levels are sampled on the rising clock edge. A write is active while both selects and the write strobe are low. Any of these inputs returning high ends the write. The word is stored on the first edge at which the write is no longer active, using the address and input data present at that edge. This matches a part that latches data on the edge that terminates the write.

Read data is registered, so the outputs follow the inputs by one clock. A build-time parameter selects how the outputs behave during a write. In one variant the data being written is passed through to the outputs. In the other variant the outputs float while the write strobe is low. Depth and word width are parameters. The 16K-word by 4-bit organisation is obtained with an address width of 14.

Top module: `sram_dual_sel`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (default 10 and 4; ADDR_W=14 gives 16,384 words), and every address from 0 to the top one keeps its own word.
- R2: A write is active only while sel_a_n, sel_b_n and wr_n are all sampled low; with either select high, wr_n low stores nothing.
- R3: A word is stored on the first clock edge at which the write is no longer active after having been active, at the address and with the din value sampled at that edge. This applies whether wr_n or a select ended the write.
- R4: When not writing through, the registered output takes the word at the sampled address one clock after the edge. On a storing edge it shows the newly stored value.
- R5: dout_en is high in the cycle after an edge where both selects and oe_n were sampled low and the variant allows drive. dout is zero whenever dout_en is low.
- R6: With WRITE_THRU=0, dout_en is low in the cycle after any edge where wr_n was sampled low. This includes an edge where a select and wr_n return high together.
- R7: With WRITE_THRU=1, after an edge where a write was active and oe_n was low, dout_en is high and dout equals the din sampled at that edge.
- R8: pdown is high in the cycle after any edge where either select was sampled high, and low otherwise.
- R9: While rst_n is low, dout_en is 0, dout is 0 and pdown is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| pdown | output | 1 | Deselected / power-down flag |

## Verification
The bench builds two instances with ADDR_W=6 and DATA_W=4, and feeds both from the same inputs. One instance uses WRITE_THRU=1 and the other WRITE_THRU=0. The small address space lets the stimulus store words at address 0 and address 63. Running both variants side by side compares pass-through against floating on the same write cycles. This covers writes ended by the strobe, writes ended by a select, and writes ended by both together.

// File: rtl/sram_dual_sel.sv
module sram_dual_sel #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 4,
  parameter bit WRITE_THRU = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pdown
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              wr_act_q;
  logic              en_q;
  logic              pd_q;

  wire sel    = ~sel_a_n & ~sel_b_n;
  wire wr_act = sel & ~wr_n;
  wire commit = wr_act_q & ~wr_act;
  wire drive  = sel & ~oe_n & (WRITE_THRU | wr_n);

  always_ff @(posedge clk)
    if (commit) mem[addr] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      en_q     <= 1'b0;
      pd_q     <= 1'b1;
      rd_q     <= '0;
    end else begin
      wr_act_q <= wr_act;
      en_q     <= drive;
      pd_q     <= ~sel;
      if ((WRITE_THRU && wr_act) || commit) rd_q <= din;
      else                                  rd_q <= mem[addr];
    end

  assign dout    = en_q ? rd_q : '0;
  assign dout_en = en_q;
  assign pdown   = pd_q;
endmodule

module sram_dual_sel_chk #(
  parameter int DATA_W     = 4,
  parameter bit WRITE_THRU = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              pdown
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

  assert_drive_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dout_en) |-> $past(!sel_a_n && !sel_b_n && !oe_n));

  assert_pdown_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pdown == $past(sel_a_n || sel_b_n)));

  if (WRITE_THRU) begin : g_thru
    assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!sel_a_n && !sel_b_n && !wr_n && !oe_n))
        |-> (dout_en && dout == $past(din)));
  end else begin : g_float
    assert_float_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(!wr_n)) |-> !dout_en);
  end
endmodule

bind sram_dual_sel sram_dual_sel_chk #(
  .DATA_W(DATA_W), .WRITE_THRU(WRITE_THRU)
) u_chk (.*);

// File: tb/sram_dual_sel_tb.sv
module sram_dual_sel_tb;
  localparam int AW = 6;
  localparam int DW = 4;

  typedef struct packed {
    logic          s1, s2, w, o;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ewt;
    logic [DW-1:0] dwt;
    logic          ehz;
    logic [DW-1:0] dhz;
    logic          pd;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TAB [NV] = '{
    '{0,0,0,0,  5,'hA, 1,'hA, 0,0, 0, 7}, // R7 write active, pass/float
    '{0,0,1,0,  5,'h3, 1,'h3, 1,'h3, 0, 3}, // R3 end by wr_n, stores din at end edge
    '{0,0,1,0,  5,'hF, 1,'h3, 1,'h3, 0, 4}, // R4 read back
    '{0,0,0,0,  9,'h6, 1,'h6, 0,0, 0, 6}, // R6 float while wr_n low
    '{1,0,0,0,  9,'hC, 0,0, 0,0, 1, 8}, // R8 select ends write
    '{0,0,1,0,  9,'h0, 1,'hC, 1,'hC, 0, 3}, // R3 stored by select edge
    '{0,1,0,0,  9,'h1, 0,0, 0,0, 1, 2}, // R2 second select high
    '{0,0,1,0,  9,'h2, 1,'hC, 1,'hC, 0, 2}, // R2 nothing stored
    '{0,0,1,1,  9,'h0, 0,0, 0,0, 0, 5}, // R5 gate off
    '{0,0,0,0, 20,'h7, 1,'h7, 0,0, 0, 7}, // R7
    '{1,1,1,0, 20,'h8, 0,0, 0,0, 1, 6}, // R6 select and wr_n rise together
    '{0,0,1,0, 20,'h0, 1,'h8, 1,'h8, 0, 3}, // R3
    '{0,0,0,1, 33,'h5, 0,0, 0,0, 0, 5}, // R5 gated write
    '{0,0,0,1, 33,'h9, 0,0, 0,0, 0, 5}, // R5
    '{0,0,1,0, 33,'h4, 1,'h4, 1,'h4, 0, 4}, // R4 bypass on storing edge
    '{0,0,1,0,  5,'h0, 1,'h3, 1,'h3, 0, 4}, // R4 older word intact
    '{0,0,0,0, 63,'hB, 1,'hB, 0,0, 0, 7}, // R7
    '{0,0,1,0,  0,'hE, 1,'hE, 1,'hE, 0, 3}, // R3 address taken at end edge
    '{0,0,1,0,  0,'h0, 1,'hE, 1,'hE, 0, 1}, // R1 bottom address
    '{0,0,0,0, 63,'hD, 1,'hD, 0,0, 0, 7}, // R7
    '{0,0,1,0, 63,'hD, 1,'hD, 1,'hD, 0, 4}, // R4
    '{0,0,1,0, 63,'h0, 1,'hD, 1,'hD, 0, 1}  // R1 top address
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s1 = 1'b1, s2 = 1'b1, w = 1'b1, o = 1'b1;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] dout_t, dout_z;
  logic en_t, en_z, pd_t, pd_z;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_a_n(s1), .sel_b_n(s2), .wr_n(w), .oe_n(o),
    .addr(a), .din(d), .dout(dout_t), .dout_en(en_t), .pdown(pd_t));

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THRU(1'b0)) u_dut_hz (
    .clk(clk), .rst_n(rst_n), .sel_a_n(s1), .sel_b_n(s2), .wr_n(w), .oe_n(o),
    .addr(a), .din(d), .dout(dout_z), .dout_en(en_z), .pdown(pd_z));

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset en_t",  {7'd0, en_t}, 8'd0);
    chk("R9", "reset en_z",  {7'd0, en_z}, 8'd0);
    chk("R9", "reset dout",  {4'd0, dout_t}, 8'd0);
    chk("R9", "reset pdown", {6'd0, pd_t, pd_z}, 8'd3);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", TAB[i].req, i);
      {s1, s2, w, o} = {TAB[i].s1, TAB[i].s2, TAB[i].w, TAB[i].o};
      a = TAB[i].a;
      d = TAB[i].d;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "en_thru",   {7'd0, en_t}, {7'd0, TAB[i].ewt});
      chk(tag, "dout_thru", {4'd0, dout_t}, {4'd0, TAB[i].dwt});
      chk(tag, "en_float",  {7'd0, en_z}, {7'd0, TAB[i].ehz});
      chk(tag, "dout_float",{4'd0, dout_z}, {4'd0, TAB[i].dhz});
      chk(tag, "pdown",     {6'd0, pd_t, pd_z}, TAB[i].pd ? 8'd3 : 8'd0);
    end
    // R9: reset mid-run while selected and reading
    {s1, s2, w, o} = 4'b0010;
    a = 6'd5;
    rst_n = 1'b0;
    #1;
    chk("R9", "midrun en",    {6'd0, en_t, en_z}, 8'd0);
    chk("R9", "midrun pdown", {6'd0, pd_t, pd_z}, 8'd3);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: stored word survives reset of the control state
    chk("R1", "after reset read", {4'd0, dout_t}, 8'h3);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule